// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Controller

This unit sits beside a small 4-bit processor core and decides when the core must break off its program to service one of two request sources: a level-sensitive external pin, whose rising edges are of interest, and the overflow pulse of the timer divider. Each source owns a sticky request flag. A per-source enable bit and a global enable decide whether a pending flag may interrupt. A fixed priority picks one source when both are eligible. On acceptance the unit raises a one-cycle strobe. The core uses it to push its program counter and to load the 12-bit vector that comes with the strobe.

The core tells the unit where instructions end. `ins_adv` is high only in the final cycle of an instruction that may be followed by an interrupt. It stays low inside two-cycle instructions, inside the second word of a return target and during skip sequences. The core also sends single-cycle strobes that set or clear the global enable and that mark a return from interrupt. A test strobe reads one flag and clears it. A combinational `stby_blk` output tells the core to refuse a standby request because a wake-up condition is already present.

Top module: `irq2_ctrl`

## Requirements
- R1: The external flag sets on a rising edge of `ext_pin` after a two-flop synchronizer, so it is first visible after the third rising clock edge that follows the pin rising. The overflow flag is visible after the first clock edge at which `div_ovf` is high.
- R2: `msk_ext` lets the external flag interrupt and `msk_ovf` lets the overflow flag interrupt. A flag whose enable bit is low still sets and stays readable, but it never produces a strobe.
- R3: When both flags are pending and enabled, the external source is taken first and the overflow source on a later acceptance.
- R4: `irq_vec` is valid while `irq_stb` is high and is formed as {page[5:0], step[5:0]}. The external source gives page 2 step 0 (0x080) and the overflow source gives page 2 step 4 (0x084).
- R5: If the global enable is set and an enabled flag is pending in a cycle with `ins_adv` high, `irq_stb` is high in the following cycle for exactly one cycle. At the end of that cycle the global enable and the serviced flag are both clear.
- R6: `rti_stb` and `ie_set` set the global enable and `ie_clr` clears it. After a return no strobe appears before the next `ins_adv`, so the return-target instruction (both words if it has two) runs first.
- R7: No strobe follows a cycle in which `ins_adv` is low, whatever flags are pending.
- R8: `stby_blk` is high when `msk_ext` is set and the synchronized pin level is high, or when `msk_ovf` is set and the overflow flag is set. Otherwise it is low.
- R9: During `tst_stb`, `tst_val` shows the flag selected by `tst_sel` (0 external, 1 overflow), and that flag is clear after the edge. Reset clears both flags, the global enable and the strobe.
- R10: Further request edges on a source whose flag is already set merge into the one pending request, which is serviced once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external request pin |
| div_ovf | input | 1 | Divider overflow pulse |
| msk_ext | input | 1 | Enable for the external source |
| msk_ovf | input | 1 | Enable for the overflow source |
| ins_adv | input | 1 | Instruction boundary where an interrupt may enter |
| ie_set | input | 1 | Strobe: set the global enable |
| ie_clr | input | 1 | Strobe: clear the global enable |
| rti_stb | input | 1 | Strobe: return from interrupt |
| tst_stb | input | 1 | Strobe: test and clear a flag |
| tst_sel | input | 1 | Flag picked by the test (0 external, 1 overflow) |
| irq_stb | output | 1 | Acceptance strobe (push PC, load vector) |
| irq_vec | output | 12 | Vector address, valid with `irq_stb` |
| ie_o | output | 1 | Global enable state |
| flag_ext_o | output | 1 | External request flag |
| flag_ovf_o | output | 1 | Overflow request flag |
| tst_val | output | 1 | Value of the tested flag |
| stby_blk | output | 1 | Standby entry must be refused |

## Verification
The sweep covers all combinations of the two flags, the two enable bits and the global enable. Each combination is followed by a single boundary cycle. This separates a mask that wrongly gates a flag from a priority error and from a wrong vector, and it checks `stby_blk` in every combination. Directed sequences check the pin synchronizer latency to the exact cycle and the order of service when both sources are pending. They also check that the strobe waits through a two-word return target with `ins_adv` held low, that repeated pin pulses are merged into one request, and that a test read clears its flag.

// File: rtl/irq2_pkg.sv
package irq2_pkg;

  typedef enum logic [0:0] {
    SRC_EXT = 1'b0,
    SRC_OVF = 1'b1
  } irq_src_e;

  localparam int unsigned NSRC = 2;

  // Vector address: page in the upper field, step in the lower field.
  function automatic int unsigned vec_addr(input int unsigned page,
                                           input int unsigned step,
                                           input int unsigned step_w);
    return (page << step_w) | step;
  endfunction

endpackage

// File: rtl/irq2_sync_edge.sv
module irq2_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      prev <= sh[STAGES-1];
    end
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/irq2_req_flag.sv
module irq2_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // A new request in the same cycle as a clear is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq2_arb.sv
module irq2_arb
  import irq2_pkg::*;
#(
  parameter int PC_W = 12,
  parameter logic [PC_W-1:0] VEC_EXT = '0,
  parameter logic [PC_W-1:0] VEC_OVF = '0
) (
  input  logic [NSRC-1:0] pend,
  output logic            any,
  output irq_src_e        win,
  output logic [PC_W-1:0] win_vec
);
  always_comb begin
    any     = |pend;
    win     = pend[SRC_EXT] ? SRC_EXT : SRC_OVF;
    win_vec = (win == SRC_EXT) ? VEC_EXT : VEC_OVF;
  end
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
  import irq2_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_W      = 6,
  parameter int STEP_W      = 6,
  parameter int VEC_PAGE    = 2,
  parameter int STEP_EXT    = 0,
  parameter int STEP_OVF    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              div_ovf,
  input  logic              msk_ext,
  input  logic              msk_ovf,
  input  logic              ins_adv,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              rti_stb,
  input  logic              tst_stb,
  input  logic              tst_sel,
  output logic              irq_stb,
  output logic [PAGE_W+STEP_W-1:0] irq_vec,
  output logic              ie_o,
  output logic              flag_ext_o,
  output logic              flag_ovf_o,
  output logic              tst_val,
  output logic              stby_blk
);
  localparam int PC_W = PAGE_W + STEP_W;
  localparam logic [PC_W-1:0] VEC_EXT = PC_W'(vec_addr(VEC_PAGE, STEP_EXT, STEP_W));
  localparam logic [PC_W-1:0] VEC_OVF = PC_W'(vec_addr(VEC_PAGE, STEP_OVF, STEP_W));

  // Named internal events
  logic            pin_lvl, ext_rise;
  logic [NSRC-1:0] set_v, clr_v, flags, ena, pend;
  logic            any, fire;
  irq_src_e        win;
  logic [PC_W-1:0] win_vec;
  logic            take_q, ie_q;
  irq_src_e        src_q;
  logic [PC_W-1:0] vec_q;

  irq2_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_pin), .level(pin_lvl), .rise(ext_rise)
  );

  assign set_v[SRC_EXT] = ext_rise;
  assign set_v[SRC_OVF] = div_ovf;
  assign ena[SRC_EXT]   = msk_ext;
  assign ena[SRC_OVF]   = msk_ovf;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign clr_v[i] = (tst_stb && (tst_sel == i[0])) || (take_q && (src_q == irq_src_e'(i)));
    irq2_req_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]), .flag_o(flags[i])
    );
  end

  assign pend = flags & ena;

  irq2_arb #(.PC_W(PC_W), .VEC_EXT(VEC_EXT), .VEC_OVF(VEC_OVF)) u_arb (
    .pend(pend), .any(any), .win(win), .win_vec(win_vec)
  );

  assign fire = ie_q && ins_adv && any && !take_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= SRC_EXT;
      vec_q  <= '0;
      ie_q   <= 1'b0;
    end else begin
      take_q <= fire;
      if (fire) begin
        src_q <= win;
        vec_q <= win_vec;
      end
      if (ie_clr || take_q)       ie_q <= 1'b0;
      else if (rti_stb || ie_set) ie_q <= 1'b1;
    end
  end

  assign irq_stb    = take_q;
  assign irq_vec    = vec_q;
  assign ie_o       = ie_q;
  assign flag_ext_o = flags[SRC_EXT];
  assign flag_ovf_o = flags[SRC_OVF];
  assign tst_val    = tst_sel ? flags[SRC_OVF] : flags[SRC_EXT];
  assign stby_blk   = (msk_ext && pin_lvl) || (msk_ovf && flags[SRC_OVF]);
endmodule

// File: rtl/irq2_ctrl_chk.sv
module irq2_ctrl_chk #(
  parameter int PC_W = 12,
  parameter logic [PC_W-1:0] VEC_EXT = '0,
  parameter logic [PC_W-1:0] VEC_OVF = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_adv,
  input logic            msk_ext,
  input logic            msk_ovf,
  input logic            ie_clr,
  input logic            rti_stb,
  input logic            irq_stb,
  input logic [PC_W-1:0] irq_vec,
  input logic            ie_o,
  input logic            flag_ext_o
);
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |=> !irq_stb);
  assert_stb_drops_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |=> !ie_o);
  assert_stb_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |-> $past(ie_o));
  assert_boundary_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |-> $past(ins_adv));
  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stb |-> (irq_vec == VEC_EXT || irq_vec == VEC_OVF));
  assert_ext_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stb && irq_vec == VEC_OVF) |-> $past(!(flag_ext_o && msk_ext)));
  assert_ext_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stb && irq_vec == VEC_EXT) |-> $past(msk_ext));
  assert_ovf_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stb && irq_vec == VEC_OVF) |-> $past(msk_ovf));
  assert_rti_sets_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_stb && !ie_clr && !irq_stb) |=> ie_o);
endmodule

bind irq2_ctrl irq2_ctrl_chk #(.PC_W(PC_W), .VEC_EXT(VEC_EXT), .VEC_OVF(VEC_OVF)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_adv(ins_adv), .msk_ext(msk_ext), .msk_ovf(msk_ovf),
  .ie_clr(ie_clr), .rti_stb(rti_stb), .irq_stb(irq_stb), .irq_vec(irq_vec),
  .ie_o(ie_o), .flag_ext_o(flag_ext_o)
);

// File: tb/irq2_ctrl_tb.sv
module irq2_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pin = 0, div_ovf = 0, msk_ext = 0, msk_ovf = 0, ins_adv = 0;
  logic ie_set = 0, ie_clr = 0, rti_stb = 0, tst_stb = 0, tst_sel = 0;
  logic irq_stb, ie_o, flag_ext_o, flag_ovf_o, tst_val, stby_blk;
  logic [11:0] irq_vec;
  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [11:0] V_EXT = (12'd2 << 6) | 12'd0;
  localparam logic [11:0] V_OVF = (12'd2 << 6) | 12'd4;

  always #4 clk = ~clk;

  irq2_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .div_ovf(div_ovf),
    .msk_ext(msk_ext), .msk_ovf(msk_ovf), .ins_adv(ins_adv), .ie_set(ie_set),
    .ie_clr(ie_clr), .rti_stb(rti_stb), .tst_stb(tst_stb), .tst_sel(tst_sel),
    .irq_stb(irq_stb), .irq_vec(irq_vec), .ie_o(ie_o), .flag_ext_o(flag_ext_o),
    .flag_ovf_o(flag_ovf_o), .tst_val(tst_val), .stby_blk(stby_blk)
  );

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    ext_pin = 0; div_ovf = 0; msk_ext = 0; msk_ovf = 0; ins_adv = 0;
    ie_set = 0; ie_clr = 0; rti_stb = 0; tst_stb = 0; tst_sel = 0;
    rst_n = 0; tick(2); rst_n = 1; tick(1);
  endtask

  task automatic pin_pulse();
    ext_pin = 1; tick(3); ext_pin = 0; tick(3);
  endtask

  task automatic ovf_pulse();
    div_ovf = 1; tick(1); div_ovf = 0;
  endtask

  task automatic enable_ie();
    ie_set = 1; tick(1); ie_set = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nstb;
    do_reset();
    // R9 reset state
    ck("R9 reset stb", irq_stb, 0);
    ck("R9 reset ie", ie_o, 0);
    ck("R9 reset flags", {flag_ext_o, flag_ovf_o}, 0);

    // R1 synchronizer latency of the external flag
    ext_pin = 1; tick(2);
    ck("R1 ext flag not yet", flag_ext_o, 0);
    tick(1);
    ck("R1 ext flag set", flag_ext_o, 1);
    ext_pin = 0;
    div_ovf = 1; tick(1); div_ovf = 0;
    ck("R1 ovf flag set", flag_ovf_o, 1);

    // R9 test and clear
    tst_stb = 1; tst_sel = 1; #1;
    ck("R9 tst_val ovf", tst_val, 1);
    tick(1); tst_stb = 0;
    ck("R9 ovf cleared", flag_ovf_o, 0);
    ck("R9 ext untouched", flag_ext_o, 1);
    tst_stb = 1; tst_sel = 0; #1;
    ck("R9 tst_val ext", tst_val, 1);
    tick(1); tst_stb = 0; #1;
    ck("R9 tst_val after clear", tst_val, 0);

    // Sweep: flags x enables x global enable
    for (int i = 0; i < 32; i++) begin
      logic fe, fo, me, mo, ie, exp;
      {ie, fo, fe, mo, me} = i[4:0];
      do_reset();
      ck("R9 reset flags sweep", {flag_ext_o, flag_ovf_o, ie_o}, 0);
      if (fe) pin_pulse();
      if (fo) ovf_pulse();
      msk_ext = me; msk_ovf = mo;
      if (ie) enable_ie();
      tick(1);
      ck("R1 R2 flags held", {flag_ext_o, flag_ovf_o}, {fe, fo});
      ck("R6 ie level", ie_o, ie);
      ck("R8 stby_blk", stby_blk, mo & fo);
      ck("R7 no stb without boundary", irq_stb, 0);
      ins_adv = 1; tick(1); ins_adv = 0;
      exp = ie & ((fe & me) | (fo & mo));
      ck("R2 R5 strobe", irq_stb, exp);
      if (exp) ck("R3 R4 vector", irq_vec, (fe & me) ? V_EXT : V_OVF);
      tick(1);
      ck("R5 single cycle", irq_stb, 0);
      if (exp) ck("R5 ie cleared", ie_o, 0);
    end

    // R3 R6 R7 order of service and return
    do_reset();
    pin_pulse(); ovf_pulse();
    msk_ext = 1; msk_ovf = 1; enable_ie();
    ins_adv = 1; tick(1); ins_adv = 0;
    ck("R3 ext first", irq_vec, V_EXT);
    ck("R5 stb", irq_stb, 1);
    tick(1);
    ck("R5 ext cleared", flag_ext_o, 0);
    ck("R3 ovf still pending", flag_ovf_o, 1);
    ins_adv = 1; tick(2);
    ck("R5 no stb with ie low", irq_stb, 0);
    rti_stb = 1; tick(1); rti_stb = 0; ins_adv = 0;
    ck("R6 ie restored", ie_o, 1);
    ck("R6 no stb at return", irq_stb, 0);
    tick(2);
    ck("R7 wait two-word target", irq_stb, 0);
    ins_adv = 1; tick(1); ins_adv = 0;
    ck("R6 ovf taken after target", irq_stb, 1);
    ck("R3 ovf vector", irq_vec, V_OVF);
    tick(1);

    // R6 enable strobes
    enable_ie();
    ck("R6 ie_set", ie_o, 1);
    ie_clr = 1; tick(1); ie_clr = 0;
    ck("R6 ie_clr", ie_o, 0);

    // R10 coalescing
    do_reset();
    pin_pulse(); pin_pulse(); pin_pulse();
    msk_ext = 1; enable_ie();
    nstb = 0;
    ins_adv = 1;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      if (irq_stb) nstb++;
    end
    rti_stb = 1; tick(1); rti_stb = 0;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      if (irq_stb) nstb++;
    end
    ins_adv = 0;
    ck("R10 one service", nstb, 1);
    ck("R10 flag clear", flag_ext_o, 0);

    // R8 pin level blocks standby
    do_reset();
    msk_ext = 1; ext_pin = 1; tick(1); #1;
    ck("R8 before sync", stby_blk, 0);
    tick(1); #1;
    ck("R8 pin high", stby_blk, 1);
    msk_ext = 0; #1;
    ck("R8 pin masked", stby_blk, 0);
    ext_pin = 0; tick(3);
    msk_ext = 1; #1;
    ck("R8 pin low", stby_blk, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule